// File: doc/BRIEF.md
# Variable-Length Opcode Stream Decoder

This block sits between an instruction byte source and an execution unit of a small 8-bit processor. Bytes come in one per accepted beat. The first byte of each instruction is the opcode. The block looks the opcode up in a fixed, irregular map and learns four things: the instruction class, whether zero, one or two immediate bytes follow, whether a one-byte immediate is sign-extended, and whether the byte is the address-width prefix. It then gathers the immediate bytes and presents one decoded record. The record is held until the consumer takes it.

A record carries the following:
- the raw opcode and its two 3-bit operand fields;
- a class code;
- a 16-bit immediate, assembled low byte first, sign- or zero-extended as the opcode requires;
- the program address just past the opcode;
- a flag that is set when the instruction was preceded by the prefix byte.

The prefix produces no record. It only arms a latch that marks the next record and is cleared once that record is accepted. Opcodes with no defined meaning are reported through an illegal flag and consume no immediate bytes.

The control is a four-state machine:
- `ST_OPCODE` waits for an opcode. A prefix stays here. An opcode with no immediate goes to `ST_EMIT`. Any other opcode goes to `ST_IMM_LO`.
- `ST_IMM_LO` takes the low immediate byte. For a two-byte immediate it goes to `ST_IMM_HI`, otherwise to `ST_EMIT`.
- `ST_IMM_HI` takes the high byte and goes to `ST_EMIT`.
- `ST_EMIT` presents the record and returns to `ST_OPCODE` on the output handshake.

Top module: `opcode_stream_decoder`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, no prefix is pending, and the first accepted byte sits at address RESET_PC.
- R2: Two-byte immediates follow these opcodes: 00001001, 00ccc111, 1110 11ww, 10111110 and 10110111. One-byte immediates follow these opcodes: 00ddd010, 00bbb011, 00ccc110, 00100001, 1110 10ww, and 11 0x 11ww (x = either bit). All other opcodes take no immediate.
- R3: A two-byte immediate is received low byte first, and out_imm = {second byte, first byte}.
- R4: A one-byte immediate is sign-extended for 00ccc110, 1110 10ww and 11 0x 11ww, and zero-extended for 00ddd010, 00bbb011 and 00100001. When there is no immediate, out_imm is 0.
- R5: out_class codes are: 0 arithmetic/logic, 1 move, 2 memory access, 3 16-bit arithmetic, 4 branch/control, 5 stack, 6 system, 7 illegal. The assignments are as follows.
  - Codes 0 and 6 from 00xxx000: 00000000 is 6 and the rest are 0.
  - Code 4 from 00xxx001 and 00xxx11x; code 1 from 00xxx010; code 0 from 00xxx011; code 5 from 00xxx100 and 00xxx101.
  - Code 0 from 01xxxxxx.
  - The 10dddrrr group: 10111110 and 10110111 are 2. When ddd equals rrr the code is 6, except 10101101 and 10111111. All other 10dddrrr are 1.
  - Code 2 from 1100xxxx and 1101xxxx.
  - From 1110xxxx: 1110 11ww is 1 and the rest are 3.
  - From 1111vvww: 1 when vv differs from ww, 6 for 11111010 and 11111111.
- R6: Opcodes 10101101, 10111111, 11110000 and 11110101 give out_illegal=1 and class 7, take no immediate bytes, and have out_imm=0. No other opcode sets out_illegal.
- R7: Opcode 10000000 produces no record. The next record has out_wide=1. After that record is accepted, the following record has out_wide=0. Repeated prefixes before one instruction still mark only that instruction.
- R8: out_pc equals the opcode's byte address plus 1. Every accepted byte advances the address by one, including prefixes and immediate bytes.
- R9: While out_valid=1 and out_ready=0, the record stays stable and in_ready=0, so no byte is taken.
- R10: out_opcode is the opcode byte, out_hi_field is opcode[5:3], and out_lo_field is opcode[2:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction byte offered |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Byte is taken on this edge when in_valid is high |
| out_valid | output | 1 | Decoded record present |
| out_ready | input | 1 | Consumer takes the record |
| out_opcode | output | 8 | Opcode byte of the record |
| out_class | output | 3 | Class code (R5) |
| out_hi_field | output | 3 | Opcode bits 5:3 |
| out_lo_field | output | 3 | Opcode bits 2:0 |
| out_imm | output | 16 | Assembled immediate |
| out_pc | output | ADDR_W | Address just past the opcode |
| out_wide | output | 1 | Instruction followed a prefix |
| out_illegal | output | 1 | Undefined opcode |

## Verification
All 255 non-prefix opcode values are sent in turn, each followed by the immediate bytes the bench expects. The immediate bytes are derived from the opcode and have mixed high bits. This separates the three immediate lengths, sign extension from zero extension, and the illegal codes from their legal neighbours in the register-move and 16-bit-move groups. Prefix sequences show that the wide flag lasts for exactly one record. A stalled consumer with a byte still offered shows that the record holds and that the address count does not move.

// File: rtl/osd_pkg.sv
package osd_pkg;
    typedef enum logic [2:0] {
        CL_ALU     = 3'd0,
        CL_MOVE    = 3'd1,
        CL_MEM     = 3'd2,
        CL_WIDE    = 3'd3,
        CL_BRANCH  = 3'd4,
        CL_STACK   = 3'd5,
        CL_SYSTEM  = 3'd6,
        CL_ILLEGAL = 3'd7
    } op_class_e;

    typedef enum logic [1:0] {
        IMM_NONE = 2'd0,
        IMM_BYTE = 2'd1,
        IMM_WORD = 2'd2
    } imm_len_e;

    typedef struct packed {
        op_class_e cls;
        imm_len_e  len;
        logic      sext;
        logic      prefix;
    } op_info_t;

    localparam logic [7:0] PREFIX_OP = 8'h80;
endpackage

// File: rtl/osd_opcode_map.sv
module osd_opcode_map
    import osd_pkg::*;
(
    input  logic [7:0] op,
    output op_info_t   info
);
    logic [2:0] hi3;
    logic [2:0] lo3;
    assign hi3 = op[5:3];
    assign lo3 = op[2:0];

    always_comb begin
        info = '{cls: CL_ALU, len: IMM_NONE, sext: 1'b0, prefix: 1'b0};
        unique case (op[7:6])
            2'b00: begin
                unique case (lo3)
                    3'b000: info.cls = (hi3 == 3'b000) ? CL_SYSTEM : CL_ALU;
                    3'b001: begin
                        info.cls = CL_BRANCH;
                        if (hi3 == 3'b001)      info.len = IMM_WORD;
                        else if (hi3 == 3'b100) info.len = IMM_BYTE;
                    end
                    3'b010: begin
                        info.cls = CL_MOVE;
                        info.len = IMM_BYTE;
                    end
                    3'b011: begin
                        info.cls = CL_ALU;
                        info.len = IMM_BYTE;
                    end
                    3'b100, 3'b101: info.cls = CL_STACK;
                    3'b110: begin
                        info.cls  = CL_BRANCH;
                        info.len  = IMM_BYTE;
                        info.sext = 1'b1;
                    end
                    default: begin
                        info.cls = CL_BRANCH;
                        info.len = IMM_WORD;
                    end
                endcase
            end
            2'b01: info.cls = CL_ALU;
            2'b10: begin
                if (op == PREFIX_OP) begin
                    info.cls    = CL_SYSTEM;
                    info.prefix = 1'b1;
                end else if (op == 8'hBE || op == 8'hB7) begin
                    info.cls = CL_MEM;
                    info.len = IMM_WORD;
                end else if (hi3 == lo3) begin
                    info.cls = (op == 8'hAD || op == 8'hBF) ? CL_ILLEGAL : CL_SYSTEM;
                end else begin
                    info.cls = CL_MOVE;
                end
            end
            default: begin
                unique case (op[5:4])
                    2'b00, 2'b01: begin
                        info.cls = CL_MEM;
                        if (op[3:2] == 2'b11) begin
                            info.len  = IMM_BYTE;
                            info.sext = 1'b1;
                        end
                    end
                    2'b10: begin
                        unique case (op[3:2])
                            2'b00, 2'b01: info.cls = CL_WIDE;
                            2'b10: begin
                                info.cls  = CL_WIDE;
                                info.len  = IMM_BYTE;
                                info.sext = 1'b1;
                            end
                            default: begin
                                info.cls = CL_MOVE;
                                info.len = IMM_WORD;
                            end
                        endcase
                    end
                    default: begin
                        if (op[3:2] != op[1:0])  info.cls = CL_MOVE;
                        else if (op[3] == 1'b0)  info.cls = CL_ILLEGAL;
                        else                     info.cls = CL_SYSTEM;
                    end
                endcase
            end
        endcase
    end
endmodule

// File: rtl/osd_imm_assembler.sv
module osd_imm_assembler
    import osd_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                cap_lo,
    input  logic                cap_hi,
    input  logic [BYTE_W-1:0]   byte_in,
    input  imm_len_e            len,
    input  logic                sext,
    output logic [2*BYTE_W-1:0] imm
);
    logic [BYTE_W-1:0] lo_q;
    logic [BYTE_W-1:0] hi_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (cap_lo) lo_q <= byte_in;
            if (cap_hi) hi_q <= byte_in;
        end
    end

    always_comb begin
        unique case (len)
            IMM_BYTE: imm = sext ? {{BYTE_W{lo_q[BYTE_W-1]}}, lo_q} : {{BYTE_W{1'b0}}, lo_q};
            IMM_WORD: imm = {hi_q, lo_q};
            default:  imm = '0;
        endcase
    end

    // R3
    hi_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_hi && !clr) |=> hi_q == $past(byte_in));
endmodule

// File: rtl/osd_fetch_fsm.sv
module osd_fetch_fsm
    import osd_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    input  op_info_t          in_info,
    input  logic              out_ready,
    output logic              in_ready,
    output logic              out_valid,
    output logic [7:0]        op_q,
    output op_info_t          info_q,
    output logic [ADDR_W-1:0] rec_pc,
    output logic              wide_q,
    output logic              start_op,
    output logic              cap_lo,
    output logic              cap_hi
);
    typedef enum logic [1:0] {
        ST_OPCODE = 2'd0,
        ST_IMM_LO = 2'd1,
        ST_IMM_HI = 2'd2,
        ST_EMIT   = 2'd3
    } fetch_state_e;

    fetch_state_e      state_q;
    fetch_state_e      state_d;
    logic [ADDR_W-1:0] byte_pc;
    logic              pend_q;
    logic              accept;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OPCODE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPCODE: if (accept && !in_info.prefix)
                           state_d = (in_info.len == IMM_NONE) ? ST_EMIT : ST_IMM_LO;
            ST_IMM_LO: if (accept)
                           state_d = (info_q.len == IMM_WORD) ? ST_IMM_HI : ST_EMIT;
            ST_IMM_HI: if (accept) state_d = ST_EMIT;
            default:   if (out_ready) state_d = ST_OPCODE;
        endcase
    end

    always_comb begin
        in_ready  = (state_q != ST_EMIT);
        out_valid = (state_q == ST_EMIT);
        accept    = in_valid && in_ready;
        start_op  = accept && (state_q == ST_OPCODE) && !in_info.prefix;
        cap_lo    = accept && (state_q == ST_IMM_LO);
        cap_hi    = accept && (state_q == ST_IMM_HI);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_pc <= RESET_PC;
            pend_q  <= 1'b0;
            op_q    <= '0;
            info_q  <= '{cls: CL_ALU, len: IMM_NONE, sext: 1'b0, prefix: 1'b0};
            rec_pc  <= '0;
            wide_q  <= 1'b0;
        end else begin
            if (accept) byte_pc <= byte_pc + 1'b1;
            if (accept && state_q == ST_OPCODE && in_info.prefix) pend_q <= 1'b1;
            else if (out_valid && out_ready)                      pend_q <= 1'b0;
            if (start_op) begin
                op_q   <= in_byte;
                info_q <= in_info;
                rec_pc <= byte_pc + 1'b1;
                wide_q <= pend_q;
            end
        end
    end

    // R8
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> byte_pc == $past(byte_pc) + 1'b1);
    // R7
    prefix_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && state_q == ST_OPCODE && in_info.prefix) |=> pend_q && !out_valid);
    // R7
    prefix_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> !pend_q);
    // R9
    hold_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid && $stable(op_q) && $stable(rec_pc) && $stable(byte_pc));
endmodule

// File: rtl/opcode_stream_decoder.sv
module opcode_stream_decoder
    import osd_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    output logic              in_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_opcode,
    output logic [2:0]        out_class,
    output logic [2:0]        out_hi_field,
    output logic [2:0]        out_lo_field,
    output logic [15:0]       out_imm,
    output logic [ADDR_W-1:0] out_pc,
    output logic              out_wide,
    output logic              out_illegal
);
    op_info_t in_info;
    op_info_t info_q;
    logic     start_op;
    logic     cap_lo;
    logic     cap_hi;

    osd_opcode_map u_map (
        .op   (in_byte),
        .info (in_info)
    );

    osd_fetch_fsm #(
        .ADDR_W   (ADDR_W),
        .RESET_PC (RESET_PC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_byte   (in_byte),
        .in_info   (in_info),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .op_q      (out_opcode),
        .info_q    (info_q),
        .rec_pc    (out_pc),
        .wide_q    (out_wide),
        .start_op  (start_op),
        .cap_lo    (cap_lo),
        .cap_hi    (cap_hi)
    );

    osd_imm_assembler #(
        .BYTE_W (8)
    ) u_imm (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (start_op),
        .cap_lo  (cap_lo),
        .cap_hi  (cap_hi),
        .byte_in (in_byte),
        .len     (info_q.len),
        .sext    (info_q.sext),
        .imm     (out_imm)
    );

    assign out_class    = info_q.cls;
    assign out_illegal  = (info_q.cls == CL_ILLEGAL);
    assign out_hi_field = out_opcode[5:3];
    assign out_lo_field = out_opcode[2:0];

    // R6
    illegal_noimm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_illegal) |-> out_imm == 16'h0000);
    // R4
    branch_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_opcode[7:6] == 2'b00 && out_opcode[2:0] == 3'b110)
            |-> out_imm[15:8] == {8{out_imm[7]}});
endmodule

// File: tb/opcode_stream_decoder_test.sv
`timescale 1ns/1ps
module opcode_stream_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        in_ready;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  out_opcode;
    logic [2:0]  out_class;
    logic [2:0]  out_hi_field;
    logic [2:0]  out_lo_field;
    logic [15:0] out_imm;
    logic [15:0] out_pc;
    logic        out_wide;
    logic        out_illegal;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    logic [15:0] exp_pc = 16'h0000;

    always #2.5 clk = ~clk;

    opcode_stream_decoder uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
        .out_opcode(out_opcode), .out_class(out_class), .out_hi_field(out_hi_field),
        .out_lo_field(out_lo_field), .out_imm(out_imm), .out_pc(out_pc),
        .out_wide(out_wide), .out_illegal(out_illegal)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic int exp_len(input logic [7:0] op);
        if (op[7:6] == 2'b00) begin
            if (op[2:0] == 3'b010 || op[2:0] == 3'b011 || op[2:0] == 3'b110) return 1;
            if (op[2:0] == 3'b111) return 2;
            if (op == 8'h09) return 2;
            if (op == 8'h21) return 1;
            return 0;
        end
        if (op == 8'hBE || op == 8'hB7) return 2;
        if (op[7:2] == 6'b111011) return 2;
        if (op[7:2] == 6'b111010) return 1;
        if (op[7:5] == 3'b110 && op[3:2] == 2'b11) return 1;
        return 0;
    endfunction

    function automatic bit exp_sext(input logic [7:0] op);
        return (op[7:6] == 2'b00 && op[2:0] == 3'b110) || (op[7:2] == 6'b111010) ||
               (op[7:5] == 3'b110 && op[3:2] == 2'b11);
    endfunction

    function automatic logic [2:0] exp_cls(input logic [7:0] op);
        if (op == 8'hAD || op == 8'hBF || op == 8'hF0 || op == 8'hF5) return 3'd7;
        case (op[7:6])
            2'b00: case (op[2:0])
                3'b000: return (op == 8'h00) ? 3'd6 : 3'd0;
                3'b010: return 3'd1;
                3'b011: return 3'd0;
                3'b100, 3'b101: return 3'd5;
                default: return 3'd4;
            endcase
            2'b01: return 3'd0;
            2'b10: begin
                if (op == 8'hBE || op == 8'hB7) return 3'd2;
                if (op[5:3] == op[2:0]) return 3'd6;
                return 3'd1;
            end
            default: begin
                if (op[5] == 1'b0) return 3'd2;
                if (op[4] == 1'b0) return (op[3:2] == 2'b11) ? 3'd1 : 3'd3;
                if (op[3:2] != op[1:0]) return 3'd1;
                return 3'd6;
            end
        endcase
    endfunction

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1 in_valid = 1'b0;
        exp_pc = exp_pc + 16'd1;
    endtask

    task automatic take_record();
        int waited = 0;
        @(negedge clk);
        while (!out_valid && waited < 50) begin
            @(negedge clk);
            waited++;
        end
        check("R9 record appears", {15'd0, out_valid}, 16'd1);
    endtask

    task automatic accept_record();
        @(negedge clk);
        out_ready = 1'b1;
        @(posedge clk);
        #1 out_ready = 1'b0;
    endtask

    task automatic run_op(input logic [7:0] op, input logic [7:0] lo, input logic [7:0] hi,
                          input logic wide, input bit fields);
        logic [15:0] op_pc;
        logic [15:0] eimm;
        int n;
        n = exp_len(op);
        send_byte(op);
        op_pc = exp_pc;
        if (n >= 1) send_byte(lo);
        if (n == 2) send_byte(hi);
        if (n == 0)      eimm = 16'h0000;
        else if (n == 2) eimm = {hi, lo};
        else             eimm = exp_sext(op) ? {{8{lo[7]}}, lo} : {8'h00, lo};
        take_record();
        check($sformatf("R5 class op=%h", op), {13'd0, out_class}, {13'd0, exp_cls(op)});
        check($sformatf("R6 illegal op=%h", op), {15'd0, out_illegal}, {15'd0, exp_cls(op) == 3'd7});
        check($sformatf("R2 R3 R4 imm op=%h", op), out_imm, eimm);
        check($sformatf("R8 pc op=%h", op), out_pc, op_pc);
        check($sformatf("R7 wide op=%h", op), {15'd0, out_wide}, {15'd0, wide});
        check($sformatf("R9 busy op=%h", op), {15'd0, in_ready}, 16'd0);
        if (fields) begin
            check("R10 opcode", {8'd0, out_opcode}, {8'd0, op});
            check("R10 hi field", {13'd0, out_hi_field}, {13'd0, op[5:3]});
            check("R10 lo field", {13'd0, out_lo_field}, {13'd0, op[2:0]});
        end
        accept_record();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid at reset", {15'd0, out_valid}, 16'd0);
        check("R1 in_ready at reset", {15'd0, in_ready}, 16'd1);

        // R1: the first record is not marked as wide, and its pc is RESET_PC+1
        run_op(8'hFF, 8'h00, 8'h00, 1'b0, 1'b1);

        // R2 R3 R4 R5 R6: sweep over all non-prefix opcodes
        for (int k = 0; k < 256; k++) begin
            if (k != 8'h80)
                run_op(k[7:0], k[7:0] ^ 8'hA5, ~k[7:0], 1'b0, 1'b1);
        end

        // R7: single prefix, then an instruction with a two-byte immediate, then a plain instruction
        send_byte(8'h80);
        @(negedge clk);
        check("R7 prefix emits nothing", {15'd0, out_valid}, 16'd0);
        run_op(8'h37, 8'h34, 8'h12, 1'b1, 1'b0);
        run_op(8'h4A, 8'h00, 8'h00, 1'b0, 1'b0);

        // R7: two prefixes in a row still mark only one instruction
        send_byte(8'h80);
        send_byte(8'h80);
        run_op(8'hAD, 8'h00, 8'h00, 1'b1, 1'b0);
        run_op(8'h2E, 8'h80, 8'h00, 1'b0, 1'b0);

        // R9: a stalled consumer with a byte still offered
        send_byte(8'h3A);
        send_byte(8'h9C);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = 8'hFF;
        for (int s = 0; s < 3; s++) begin
            @(negedge clk);
            check("R9 hold valid", {15'd0, out_valid}, 16'd1);
            check("R9 hold imm", out_imm, 16'h009C);
            check("R9 hold opcode", {8'd0, out_opcode}, 16'h003A);
            check("R9 no intake", {15'd0, in_ready}, 16'd0);
        end
        in_valid = 1'b0;
        accept_record();
        // R8: the byte offered during the stall was not counted
        run_op(8'hEE, 8'h11, 8'h22, 1'b0, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule